// File: doc/BRIEF.md
# Two's Complement Arithmetic and Logic Unit with Status Flags

This block is a purely combinational arithmetic and logic unit for two's complement integers. It takes two operands of a parameterised width and a three-bit function select. It returns a result of the same width and a four-bit status word. The supported functions are addition and subtraction, the bitwise AND, OR and XOR of both operands, and the bitwise inverse of the first operand alone.

Subtraction reuses the adder. The second operand is inverted and a carry-in of one is added. The carry-out of the top bit is reported as the carry flag and is never folded into the result. Overflow is a separate flag. For addition it comes from the signs of the operands and of the result. For subtraction it comes from the signs of the operands and of the subtrahend. A wrapped carry therefore does not raise overflow, and overflow does not depend on the carry. The zero flag and the negative flag describe the result for every function.

Top module: `tc_alu`

## Requirements
- R1: Function 000 (add) gives the sum of the operands modulo 2^W.
- R2: Function 001 (subtract) gives opnd_a plus the two's complement of opnd_b, modulo 2^W. Negating zero (0 - 0) gives 0, and 0 minus the most negative value gives that same most negative value.
- R3: For addition, overflow (status[3]) is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it. Operands of opposite sign never overflow.
- R4: For subtraction, overflow (status[3]) is 1 exactly when the operands' sign bits differ and the result's sign bit equals the subtrahend's sign bit.
- R5: For addition and subtraction, carry (status[2]) is the carry-out of the W-bit adder, including the +1 used in subtraction. Carry is independent of overflow: -2 + -5 gives -7 with carry 1 and overflow 0.
- R6: Functions 010, 011 and 100 give the bitwise AND, OR and XOR of the operands. Function 101 gives the bitwise inverse of opnd_a, and opnd_b has no effect on it.
- R7: For functions 010 to 101, overflow and carry are 0.
- R8: Zero (status[1]) is 1 exactly when the result is all zeros. Negative (status[0]) equals the result's top bit. This holds for all functions.
- R9: Function codes 110 and 111 give a result of 0 and status 4'b0010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand, also the minuend and the operand of the inverse function |
| opnd_b | input | W | Second operand, also the subtrahend |
| func_sel | input | 3 | Function code: 000 add, 001 sub, 010 and, 011 or, 100 xor, 101 invert A |
| result | output | W | Result of the selected function |
| status | output | 4 | {overflow, carry, zero, negative} |

## Verification
The 4-bit instance is driven with every operand pair under all eight function codes. This sweep separates wrap from overflow at every sign combination and covers the unused codes completely. The 8-bit instance receives fixed corner cases and random operands. The fixed cases are 80+80 overflowing to -96 and -2 + -5 carrying without overflow. They also include 7-(-6) overflowing at 4 bits and the negation of zero and of the most negative value. Inverting A with two different values of B shows that the second operand is ignored.

// File: rtl/tc_alu_pkg.sv
// Package: function codes and the status word layout shared by the ALU.
// Assumes: a three-bit function select; codes 110 and 111 are unused.
package tc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOTA = 3'b101
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zro;
        logic neg;
    } alu_flags_t;

endpackage

// File: rtl/tc_alu_addsub.sv
// Adder/subtractor: adds B, or the two's complement of B, to A.
// Reports the adder carry-out and the sign-rule overflow separately.
// Assumes: operands are two's complement of width W >= 2.
module tc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cry,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // Invert the subtrahend and form the wide sum with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cry   = full[W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    // Sign-rule checks on the original operands.
    always_comb begin
        // R3: adding unlike signs never overflows
        a_r3_no_overflow: assert (sub || (a[MSB] == b[MSB]) || !ovf)
            else $error("add overflow with unlike operand signs");
        // R4: subtracting like signs never overflows
        a_r4_no_overflow: assert (!sub || (a[MSB] != b[MSB]) || !ovf)
            else $error("sub overflow with like operand signs");
        // R4: a subtract overflow leaves the subtrahend's sign in the result
        a_r4_sign_match: assert (!(sub && ovf) || (sum[MSB] == b[MSB]))
            else $error("sub overflow with result sign unlike subtrahend");
    end

endmodule

// File: rtl/tc_alu_logic.sv
// Bitwise unit: AND, OR, XOR of A and B, or the inverse of A.
// Any other code yields zero. Assumes: op uses tc_alu_pkg codes.
module tc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] res
);
    import tc_alu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit function select.
        always_comb begin
            case (op)
                OP_AND:  res[i] = a[i] & b[i];
                OP_OR:   res[i] = a[i] | b[i];
                OP_XOR:  res[i] = a[i] ^ b[i];
                OP_NOTA: res[i] = ~a[i];
                default: res[i] = 1'b0;
            endcase
        end
    end

    // The inverse function must not depend on B.
    always_comb begin
        // R6: invert-A output is the complement of A whatever B holds
        a_r6_invert_a: assert (op != OP_NOTA || res == ~a)
            else $error("invert-A result does not match ~A");
    end

endmodule

// File: rtl/tc_alu_flags.sv
// Status builder: zero and negative from the result; overflow and carry
// passed on only for arithmetic functions. Assumes W >= 1.
module tc_alu_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0]           res,
    input  logic                   arith,
    input  logic                   cry_in,
    input  logic                   ovf_in,
    output tc_alu_pkg::alu_flags_t flags
);
    // Assemble the status word.
    always_comb begin
        flags.ovf = arith & ovf_in;
        flags.cry = arith & cry_in;
        flags.zro = ~|res;
        flags.neg = res[W-1];
    end

endmodule

// File: rtl/tc_alu.sv
// Top: two's complement ALU with {overflow, carry, zero, negative} status.
// Combinational; function codes per tc_alu_pkg, 110/111 give zero.
// Assumes W >= 2.
module tc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   func_sel,
    output logic [W-1:0] result,
    output logic [3:0]   status
);
    import tc_alu_pkg::*;

    logic         is_arith;
    logic         is_sub;
    logic [W-1:0] sum;
    logic         add_cry;
    logic         add_ovf;
    logic [W-1:0] bit_res;
    alu_flags_t   flags;

    // Decode the arithmetic functions.
    always_comb begin
        is_sub   = (func_sel == OP_SUB);
        is_arith = (func_sel == OP_ADD) || is_sub;
    end

    tc_alu_addsub #(.W(W)) u_addsub (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (is_sub),
        .sum (sum),
        .cry (add_cry),
        .ovf (add_ovf)
    );

    tc_alu_logic #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (func_sel),
        .res (bit_res)
    );

    // Pick the arithmetic or the bitwise result.
    always_comb result = is_arith ? sum : bit_res;

    tc_alu_flags #(.W(W)) u_flags (
        .res    (result),
        .arith  (is_arith),
        .cry_in (add_cry),
        .ovf_in (add_ovf),
        .flags  (flags)
    );

    // Drive the packed status port.
    always_comb status = flags;

    // Cross-unit checks at the top level.
    always_comb begin
        // R7: bitwise functions never report overflow or carry
        a_r7_no_arith_flags: assert (is_arith || status[3:2] == 2'b00)
            else $error("bitwise function with overflow/carry set");
        // R9: unused codes give a zero result and only the zero flag
        a_r9_unused_zero: assert (func_sel[2:1] != 2'b11 ||
                                  (result == '0 && status == 4'b0010))
            else $error("unused code gave nonzero output");
    end

endmodule

// File: tb/tc_alu_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected items, the monitor compares
// them at the falling edge. Two instances: 8-bit and 4-bit.
module tc_alu_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] a8 = '0, b8 = '0, r8;
    logic [3:0] a4 = '0, b4 = '0, r4;
    logic [2:0] f8 = '0, f4 = '0;
    logic [3:0] s8, s4;

    tc_alu #(.W(8)) dut_i (
        .opnd_a(a8), .opnd_b(b8), .func_sel(f8), .result(r8), .status(s8)
    );

    tc_alu #(.W(4)) dut4_i (
        .opnd_a(a4), .opnd_b(b4), .func_sel(f4), .result(r4), .status(s4)
    );

    typedef struct {
        bit         narrow;
        logic [7:0] er;
        logic [3:0] es;
        string      req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model written from the requirements, with integer arithmetic.
    function automatic void model(input int w, input int a, input int b,
                                  input int f, output int r, output int st);
        int mask = (1 << w) - 1;
        int maxv = (1 << (w - 1)) - 1;
        int minv = -(1 << (w - 1));
        int sa = (a > maxv) ? a - (1 << w) : a;
        int sb = (b > maxv) ? b - (1 << w) : b;
        int s = 0, sv = 0, c = 0, o = 0;
        case (f)
            0: begin s = a + b; sv = sa + sb; end
            1: begin s = a + ((~b) & mask) + 1; sv = sa - sb; end
            2: s = a & b;
            3: s = a | b;
            4: s = a ^ b;
            5: s = ~a;
            default: s = 0;
        endcase
        r = s & mask;
        if (f <= 1) begin
            c = (s >> w) & 1;
            o = (sv > maxv || sv < minv) ? 1 : 0;
        end
        st = (o << 3) | (c << 2) | ((r == 0 ? 1 : 0) << 1) | ((r >> (w - 1)) & 1);
    endfunction

    function automatic string req_of(input int f);
        case (f)
            0: return "R1/R3/R5/R8";
            1: return "R2/R4/R5/R8";
            2, 3, 4, 5: return "R6/R7/R8";
            default: return "R9";
        endcase
    endfunction

    // Drive one operation with an explicit expectation.
    task automatic drive(input bit narrow, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] f, input logic [7:0] er,
                         input logic [3:0] es, input string req);
        item_t it;
        @(posedge clk);
        #1;
        if (narrow) begin a4 = a[3:0]; b4 = b[3:0]; f4 = f; end
        else begin a8 = a; b8 = b; f8 = f; end
        it.narrow = narrow; it.er = er; it.es = es; it.req = req;
        q.push_back(it);
    endtask

    // Drive one operation with a model expectation.
    task automatic drive_m(input bit narrow, input logic [7:0] a,
                           input logic [7:0] b, input logic [2:0] f);
        int r, st;
        model(narrow ? 4 : 8, int'(a), int'(b), int'(f), r, st);
        drive(narrow, a, b, f, 8'(r), 4'(st), req_of(int'(f)));
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it = q.pop_front();
            logic [7:0] ar = it.narrow ? {4'b0, r4} : r8;
            logic [3:0] as = it.narrow ? s4 : s8;
            n_chk++;
            if (ar !== it.er || as !== it.es) begin
                n_fail++;
                $display("FAIL %s: result=%h status=%b expected result=%h status=%b",
                         it.req, ar, as, it.er, it.es);
            end
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (r8 !== 8'h00 || s8 !== 4'b0010) begin
            n_fail++;
            $display("FAIL R8 reset state: result=%h status=%b expected result=00 status=0010",
                     r8, s8);
        end
        rst_n = 1'b1;

        // R3 80+80 overflows to -96
        drive(0, 8'd80, 8'd80, 3'b000, 8'hA0, 4'b1001, "R3");
        // R5 -2 + -5 = -7 with carry, no overflow
        drive(0, 8'hFE, 8'hFB, 3'b000, 8'hF9, 4'b0101, "R5");
        // R1 -8 + 3 = -5
        drive(0, 8'hF8, 8'h03, 3'b000, 8'hFB, 4'b0001, "R1");
        // R2 8 - 5 = 3 with carry
        drive(0, 8'h08, 8'h05, 3'b001, 8'h03, 4'b0100, "R2");
        // R4 7 - (-6) overflows at 4 bits to -3
        drive(1, 8'h07, 8'h0A, 3'b001, 8'h0D, 4'b1001, "R4");
        // R3 -7 + -6 overflows at 4 bits to 3 with carry
        drive(1, 8'h09, 8'h0A, 3'b000, 8'h03, 4'b1100, "R3");
        // R2 negate zero
        drive(0, 8'h00, 8'h00, 3'b001, 8'h00, 4'b0110, "R2");
        // R2 negate most negative value
        drive(0, 8'h00, 8'h80, 3'b001, 8'h80, 4'b1001, "R2");
        // R6 invert A ignores B
        drive(0, 8'h3C, 8'h00, 3'b101, 8'hC3, 4'b0001, "R6");
        drive(0, 8'h3C, 8'hFF, 3'b101, 8'hC3, 4'b0001, "R6");
        // R6 bitwise AND/OR/XOR
        drive(0, 8'hCA, 8'h0F, 3'b010, 8'h0A, 4'b0000, "R6");
        drive(0, 8'hCA, 8'h0F, 3'b011, 8'hCF, 4'b0001, "R6");
        drive(0, 8'hCA, 8'hCA, 3'b100, 8'h00, 4'b0010, "R6/R8");
        // R9 unused codes
        drive(0, 8'hFF, 8'hFF, 3'b110, 8'h00, 4'b0010, "R9");
        drive(0, 8'h81, 8'h7E, 3'b111, 8'h00, 4'b0010, "R9");
        // R7 OR of negatives: no carry/overflow
        drive(0, 8'h80, 8'hFF, 3'b011, 8'hFF, 4'b0001, "R7");

        // Exhaustive 4-bit sweep
        for (int f = 0; f < 8; f++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    drive_m(1, 8'(a), 8'(b), 3'(f));

        // Random 8-bit patterns
        for (int k = 0; k < 2000; k++)
            drive_m(0, 8'($urandom), 8'($urandom), 3'($urandom));

        repeat (3) @(posedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                #(8 * 100000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule